// File: doc/BRIEF.md
# Memory Write/Read-Back Self-Test Sequencer

This block drives the user port of an external memory controller to run a single go/no-go check. It signals the outcome on two active-low indicator outputs. After reset it waits a start-up interval, then gives the controller a one-cycle initialisation strobe. It then waits a second, longer interval and writes one fixed test word to address zero. After that it reads address zero again and again, forever, and compares each returned word against the test word.

Both waits are long by default: about one second and ten seconds at a clock near 108 MHz. This lets a person watch the indicators change from one phase to the next. Both lengths are parameters, so a simulation can shrink them. Only one read is in flight at a time: a new read is issued only after the controller's valid pulse for the previous one. This lets the sequencer work with any fixed read latency. The pass indicator always shows the result of the most recent comparison. The progress indicator lights once the write has been issued.

The states are:
- `ST_STARTUP`: counts `STARTUP_CYCLES` cycles, then goes to `ST_INIT`.
- `ST_INIT`: lasts one cycle, strobes the controller initialisation, then goes to `ST_SETTLE`.
- `ST_SETTLE`: counts `WRITE_WAIT_CYCLES` cycles, then goes to `ST_WRITE`.
- `ST_WRITE`: lasts one cycle, issues the write, then goes to `ST_RD_ISSUE`.
- `ST_RD_ISSUE`: lasts one cycle, issues a read, then goes to `ST_RD_WAIT`.
- `ST_RD_WAIT`: holds until the controller's read-valid pulse, then goes back to `ST_RD_ISSUE`.

Top module: `mem_selftest_seq`

## Requirements
- R1: While `rst_n` is low, `mem_init`, `mem_wr` and `mem_rd` are 0, and `led_pass_n` and `led_wrote_n` are 1 (unlit). Asserting reset at any time returns the block to this state.
- R2: Number the cycles after reset release from 0, where cycle k follows the k-th rising edge. `mem_init` is 1 in cycle STARTUP_CYCLES only, and in no other cycle of the run.
- R3: `mem_wr` is 1 in cycle STARTUP_CYCLES+WRITE_WAIT_CYCLES+1 only. In that cycle `mem_rd` is 0, `mem_addr` is 0 and `mem_wdata` equals TEST_WORD.
- R4: `led_wrote_n` is 1 up to and including the write cycle. It is 0 in every later cycle until reset.
- R5: The first `mem_rd` pulse comes in the cycle right after the write, with `mem_addr` 0. Each read lasts one cycle. The next read comes in the cycle after the `mem_rvalid` pulse that answers the previous read. With a controller latency of L cycles, reads therefore repeat every L+1 cycles.
- R6: In the cycle after a `mem_rvalid` pulse whose `mem_rdata` equals TEST_WORD, `led_pass_n` is 0.
- R7: In the cycle after a `mem_rvalid` pulse whose `mem_rdata` differs from TEST_WORD, `led_pass_n` is 1. The LED shows only the most recent comparison. It changes at no other time, and before the first comparison it is 1.
- R8: At most one of `mem_init`, `mem_wr` and `mem_rd` is 1 in any cycle. No new read is issued while a read is outstanding. This holds for every controller latency of 1 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_init | output | 1 | One-cycle controller initialisation strobe |
| mem_wr | output | 1 | Write request |
| mem_rd | output | 1 | Read request |
| mem_addr | output | AW | Request address (always zero) |
| mem_wdata | output | DW | Write data (TEST_WORD during the write, otherwise 0) |
| mem_rdata | input | DW | Read data from the controller |
| mem_rvalid | input | 1 | One-cycle pulse: mem_rdata is valid |
| led_pass_n | output | 1 | Active-low pass indicator |
| led_wrote_n | output | 1 | Active-low indicator: write issued |

## Verification
An off-by-one in either delay counter appears at once as an initialisation or write strobe in the wrong cycle. The bench counts every cycle against the arithmetic schedule, so such an error is reported in the first cycle where the strobe should or should not be. A state machine stuck in the read-wait state, or one that re-issues reads too early, breaks the L+1 read period within one period. Sweeping the responder latency from 1 to 4 exposes such a fault. A wrong compare or a sticky pass register is seen in the cycle after the first corrupted read-back. That read-back falls at a different read index in each corruption pattern of the sweep.

// File: rtl/mst_pkg.sv
package mst_pkg;

    typedef enum logic [2:0] {
        ST_STARTUP  = 3'd0,
        ST_INIT     = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_WRITE    = 3'd3,
        ST_RD_ISSUE = 3'd4,
        ST_RD_WAIT  = 3'd5
    } mst_state_e;

    function automatic int unsigned mst_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mst_delay_timer.sv
module mst_delay_timer #(
    parameter int unsigned SHORT_CYCLES = 108_000_000,
    parameter int unsigned LONG_CYCLES  = 1_080_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_long,
    output logic expired
);
    localparam int unsigned MAXC = mst_pkg::mst_max(SHORT_CYCLES, LONG_CYCLES);
    localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);

    logic [CW-1:0] count_q;
    logic [CW-1:0] last_val;

    always_comb begin
        last_val = sel_long ? LONG_LAST : SHORT_LAST;
        expired  = run && (count_q == last_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run || expired) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/mst_ctrl_fsm.sv
module mst_ctrl_fsm
    import mst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_expired,
    input  logic rd_valid,
    output logic tmr_run,
    output logic tmr_long,
    output logic init_stb,
    output logic wr_stb,
    output logic rd_stb,
    output logic rd_waiting
);
    mst_state_e state_q;
    mst_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STARTUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STARTUP:  if (tmr_expired) state_d = ST_INIT;
            ST_INIT:     state_d = ST_SETTLE;
            ST_SETTLE:   if (tmr_expired) state_d = ST_WRITE;
            ST_WRITE:    state_d = ST_RD_ISSUE;
            ST_RD_ISSUE: state_d = ST_RD_WAIT;
            ST_RD_WAIT:  if (rd_valid) state_d = ST_RD_ISSUE;
            default:     state_d = ST_STARTUP;
        endcase
    end

    always_comb begin
        tmr_run    = 1'b0;
        tmr_long   = 1'b0;
        init_stb   = 1'b0;
        wr_stb     = 1'b0;
        rd_stb     = 1'b0;
        rd_waiting = 1'b0;
        unique case (state_q)
            ST_STARTUP:  tmr_run = 1'b1;
            ST_INIT:     init_stb = 1'b1;
            ST_SETTLE: begin
                tmr_run  = 1'b1;
                tmr_long = 1'b1;
            end
            ST_WRITE:    wr_stb = 1'b1;
            ST_RD_ISSUE: rd_stb = 1'b1;
            ST_RD_WAIT:  rd_waiting = 1'b1;
            default:     tmr_run = 1'b0;
        endcase
    end
endmodule

// File: rtl/mst_indicators.sv
module mst_indicators #(
    parameter int unsigned DW = 32,
    parameter logic [DW-1:0] TEST_WORD = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          rd_waiting,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          led_pass_n,
    output logic          led_wrote_n
);
    logic match;

    always_comb match = (rd_data == TEST_WORD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_wrote_n <= 1'b1;
            led_pass_n  <= 1'b1;
        end else begin
            if (wr_stb) led_wrote_n <= 1'b0;
            if (rd_waiting && rd_valid) led_pass_n <= !match;
        end
    end
endmodule

// File: rtl/mem_selftest_seq.sv
module mem_selftest_seq #(
    parameter int unsigned   DW                = 32,
    parameter int unsigned   AW                = 18,
    parameter logic [DW-1:0] TEST_WORD         = DW'(32'hA5C3_5A3C),
    parameter int unsigned   STARTUP_CYCLES    = 108_000_000,
    parameter int unsigned   WRITE_WAIT_CYCLES = 1_080_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_init,
    output logic          mem_wr,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic          led_pass_n,
    output logic          led_wrote_n
);
    logic tmr_run;
    logic tmr_long;
    logic tmr_expired;
    logic rd_waiting;

    mst_delay_timer #(
        .SHORT_CYCLES (STARTUP_CYCLES),
        .LONG_CYCLES  (WRITE_WAIT_CYCLES)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .sel_long (tmr_long),
        .expired  (tmr_expired)
    );

    mst_ctrl_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_expired (tmr_expired),
        .rd_valid    (mem_rvalid),
        .tmr_run     (tmr_run),
        .tmr_long    (tmr_long),
        .init_stb    (mem_init),
        .wr_stb      (mem_wr),
        .rd_stb      (mem_rd),
        .rd_waiting  (rd_waiting)
    );

    mst_indicators #(
        .DW        (DW),
        .TEST_WORD (TEST_WORD)
    ) ind_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (mem_wr),
        .rd_waiting  (rd_waiting),
        .rd_valid    (mem_rvalid),
        .rd_data     (mem_rdata),
        .led_pass_n  (led_pass_n),
        .led_wrote_n (led_wrote_n)
    );

    always_comb begin
        mem_addr  = '0;
        mem_wdata = mem_wr ? TEST_WORD : '0;
    end
endmodule

// File: rtl/mst_seq_chk.sv
module mst_seq_chk #(
    parameter int unsigned   DW = 32,
    parameter int unsigned   AW = 18,
    parameter logic [DW-1:0] TEST_WORD = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_init,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] mem_rdata,
    input logic          mem_rvalid,
    input logic          led_pass_n,
    input logic          led_wrote_n
);
    logic rd_open_q;
    logic wr_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_open_q <= 1'b0;
            wr_seen_q <= 1'b0;
        end else begin
            if (mem_rd) rd_open_q <= 1'b1;
            else if (mem_rvalid) rd_open_q <= 1'b0;
            if (mem_wr) wr_seen_q <= 1'b1;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_init, mem_wr, mem_rd}) <= 1); // R8
    AST_WR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == '0 && mem_wdata == TEST_WORD)); // R3
    AST_WR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !wr_seen_q); // R3
    AST_WROTE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !led_wrote_n |=> !led_wrote_n); // R4
    AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (!led_wrote_n && mem_addr == '0)); // R5
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !rd_open_q); // R8
    AST_PASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rvalid && rd_open_q) |=> (led_pass_n == ($past(mem_rdata) != TEST_WORD))); // R6 R7
    AST_PASS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rvalid && rd_open_q) |=> $stable(led_pass_n)); // R7
endmodule

bind mem_selftest_seq mst_seq_chk #(
    .DW        (DW),
    .AW        (AW),
    .TEST_WORD (TEST_WORD)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_init    (mem_init),
    .mem_wr      (mem_wr),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_rvalid  (mem_rvalid),
    .led_pass_n  (led_pass_n),
    .led_wrote_n (led_wrote_n)
);

// File: tb/mem_selftest_seq_tb.sv
module mem_selftest_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam logic [DW-1:0] TWORD = 16'hC35A;
    localparam int N = 5;
    localparam int M = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_init, mem_wr, mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          led_pass_n, led_wrote_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [DW-1:0] mem0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_selftest_seq #(
        .DW(DW), .AW(AW), .TEST_WORD(TWORD),
        .STARTUP_CYCLES(N), .WRITE_WAIT_CYCLES(M)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_init(mem_init), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .led_pass_n(led_pass_n), .led_wrote_n(led_wrote_n)
    );

    task automatic check(input string tag, input int j, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, j, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mem_rvalid = 1'b0;
        mem0 = ~TWORD;
        repeat (3) @(negedge clk);
        check("R1 init", -1, int'(mem_init), 0);
        check("R1 wr", -1, int'(mem_wr), 0);
        check("R1 rd", -1, int'(mem_rd), 0);
        check("R1 pass_led", -1, int'(led_pass_n), 1);
        check("R1 wrote_led", -1, int'(led_wrote_n), 1);
    endtask

    // one run: latency lat, read k returns corrupted data when mask[k%8]
    task automatic run(input int lat, input logic [7:0] mask);
        int cd = 0;
        int k = 0;
        int first_rd = N + M + 2;
        int len = first_rd + (lat + 1) * 10 + 2;
        do_reset();
        @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
        for (int j = 0; j <= len; j++) begin
            int exp_rd, exp_pass, c;
            @(negedge clk);
            // responder: valid pulse lat cycles after the read was seen
            if (cd > 0) begin
                cd--;
                mem_rvalid = (cd == 0);
            end else begin
                mem_rvalid = 1'b0;
            end
            check("R2 init", j, int'(mem_init), int'(j == N));
            check("R3 wr", j, int'(mem_wr), int'(j == N + M + 1));
            exp_rd = (j >= first_rd && ((j - first_rd) % (lat + 1)) == 0) ? 1 : 0;
            check("R5 rd", j, int'(mem_rd), exp_rd);
            check("R4 wrote_led", j, int'(led_wrote_n), (j >= first_rd) ? 0 : 1);
            c = (j >= first_rd + lat + 1) ? (j - (first_rd + lat + 1)) / (lat + 1) + 1 : 0;
            exp_pass = (c == 0) ? 1 : int'(mask[(c - 1) % 8]);
            check(exp_pass ? "R7 pass_led" : "R6 pass_led", j, int'(led_pass_n), exp_pass);
            if (mem_wr) begin
                check("R3 addr", j, int'(mem_addr), 0);
                check("R3 wdata", j, int'(mem_wdata), int'(TWORD));
                mem0 = mem_wdata;
            end
            if (mem_rd) begin
                check("R5 addr", j, int'(mem_addr), 0);
                check("R8 outstanding", j, cd, 0);
                mem_rdata = mask[k % 8] ? (mem0 ^ 16'h0100) : mem0;
                k++;
                cd = lat;
            end
        end
    endtask

    initial begin
        for (int lat = 1; lat <= 4; lat++) begin
            run(lat, 8'h00);
            run(lat, 8'b0000_0100);
            run(lat, 8'b0001_1010);
        end
        do_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule